// File: doc/BRIEF.md
# Bounded Event Ring Writer

This block takes completion records from a DMA engine and turns each one into a 32-byte status entry. It writes that entry into a circular event ring in memory. Software describes the ring with three values: a base address, a length counted in entries, and a dequeue pointer that marks the entry software is still working on. The writer walks the ring one entry at a time and returns to the base once the configured length is used up. It never writes over the entry that the dequeue pointer names.

When the next slot would land on the dequeue pointer, the writer keeps the pending record and pushes back on the completion input. It also sets a sticky ring-full flag. The stalled entry goes out as soon as software moves its dequeue pointer. Software clears the flag with a write-1 pulse. Every entry that is written produces a one-cycle done pulse for the interrupt logic, and that pulse carries the record's interrupt-on-complete bit.

Top module: `event_ring_writer`

## Requirements
- R1: While reset is held and after its release, `mem_req`, `ring_full` and `trb_done` are 0, and `cmp_ready` is 1.
- R2: The first entry written after the ring is enabled goes to `cfg_base`. No dequeue-pointer check is made for this first entry.
- R3: Each entry that is written moves the next slot address up by 32 bytes, unless R4 applies.
- R4: Once the number of entries written since the last return reaches `cfg_size`, the next slot is `cfg_base` again. With `cfg_size` equal to 1, every entry goes to the base.
- R5: Apart from the first entry (R2), no request is issued while the next slot equals `cfg_deq`. The pending record is held, and `cmp_ready` stays 0.
- R6: A return to the base is blocked in the same way when `cfg_deq` equals `cfg_base`.
- R7: A blocked slot sets `ring_full` in the following cycle. The flag stays set until a `full_clr` pulse arrives at a time when the ring is no longer blocked. A clear that arrives while the ring is still blocked is lost.
- R8: When `cfg_deq` moves away from the blocked slot, the held record is written to that slot.
- R9: Entry layout in `mem_data`:
  - bit 0 is the cycle bit, which is always 0;
  - bits 4:1 hold the type, which is 3 (event);
  - bit 5 is the interrupt-on-complete bit;
  - bit 6 is the completion code (1 = success, 0 = not updated);
  - bits 15:7 are 0;
  - bits 31:16 hold the length;
  - bits 63:32 hold the source pointer;
  - bits 95:64 hold the destination pointer;
  - bits 255:96 are 0.
- R10: Once `mem_req` is asserted, it stays asserted with `mem_addr` and `mem_data` unchanged until `mem_ack` is sampled high.
- R11: `trb_done` is high for exactly one cycle: the cycle after the acknowledge edge. `trb_done_ioc` carries the written record's interrupt-on-complete bit.
- R12: While `cfg_enable` is 0, the slot pointer returns to `cfg_base`, and the next entry is treated as the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Ring enable; while low, issuing stops and the pointer restarts |
| cfg_base | input | 32 | Ring base address |
| cfg_size | input | 16 | Ring length in entries |
| cfg_deq | input | 32 | Software dequeue pointer |
| full_clr | input | 1 | Write-1 clear pulse for the full flag |
| ring_full | output | 1 | Sticky ring-full flag |
| cur_slot | output | 32 | Address the next entry will be written to |
| cmp_valid | input | 1 | Completion record valid |
| cmp_ready | output | 1 | Completion record accepted |
| cmp_cc | input | 1 | Completion code |
| cmp_ioc | input | 1 | Interrupt-on-complete bit |
| cmp_len | input | 16 | Transfer length |
| cmp_src | input | 32 | Source pointer of the transfer |
| cmp_dst | input | 32 | Destination pointer of the transfer |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Write address |
| mem_data | output | 256 | Entry contents |
| mem_ack | input | 1 | Write acknowledge |
| trb_done | output | 1 | One-cycle entry-written pulse |
| trb_done_ioc | output | 1 | Interrupt-on-complete bit of the written entry |

## Verification
The assertions check the following on every cycle:
- the request holds steady until it is acknowledged;
- the done pulse is a single cycle;
- the full flag is set by a blocked slot and stays set until cleared;
- the pointer steps by 32 bytes or returns to the base;
- a newly raised request never targets the dequeue pointer, except for the first entry.

Some behaviour only the bench scenarios can show:
- the exact address sequence across wraps;
- the entry layout;
- a pending record that waits out a full ring and then lands in the right slot after the pointer moves;
- a clear that is lost while the ring is still blocked;
- a ring of one entry;
- the restart to a new base after the ring is disabled.

// File: rtl/erw_pkg.sv
package erw_pkg;

  localparam int unsigned AW       = 32;
  localparam int unsigned LW       = 16;
  localparam int unsigned TRB_W    = 256;
  localparam logic [3:0]  EVT_TYPE = 4'h3;

  typedef struct packed {
    logic          cc;
    logic          ioc;
    logic [LW-1:0] len;
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
  } cmp_rec_t;

  typedef enum logic [0:0] {
    PORT_IDLE = 1'b0,
    PORT_BUSY = 1'b1
  } port_state_e;

  // Build the 256-bit status entry from a completion record.
  function automatic logic [TRB_W-1:0] pack_entry(input cmp_rec_t r);
    logic [31:0] w0;
    w0 = {r.len, 9'b0, r.cc, r.ioc, EVT_TYPE, 1'b0};
    return {{(TRB_W-96){1'b0}}, r.dst, r.src, w0};
  endfunction

  // Does the entry just written complete one pass of the ring?
  function automatic logic pass_done(input logic [LW-1:0] idx,
                                     input logic [LW-1:0] size);
    return ({1'b0, idx} + 1'b1) >= {1'b0, size};
  endfunction

  // Address of the slot after the current one.
  function automatic logic [AW-1:0] step_slot(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] base,
                                              input logic          wrap,
                                              input int unsigned   stride);
    return wrap ? base : cur + AW'(stride);
  endfunction

endpackage

// File: rtl/erw_slot_tracker.sv
module erw_slot_tracker
  import erw_pkg::*;
#(
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned ENTRY_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [AW-1:0]     base,
  input  logic [SIZE_W-1:0] size,
  input  logic              advance,
  output logic [AW-1:0]     slot,
  output logic              fresh,
  output logic              at_last
);

  logic [AW-1:0]     slot_q;
  logic [SIZE_W-1:0] idx_q;
  logic              fresh_q;

  assign slot    = fresh_q ? base : slot_q;
  assign fresh   = fresh_q;
  assign at_last = pass_done(LW'(idx_q), LW'(size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      idx_q   <= '0;
      fresh_q <= 1'b1;
    end else if (!enable) begin
      slot_q  <= base;
      idx_q   <= '0;
      fresh_q <= 1'b1;
    end else if (advance) begin
      slot_q  <= step_slot(slot, base, at_last, ENTRY_BYTES);
      idx_q   <= at_last ? '0 : idx_q + 1'b1;
      fresh_q <= 1'b0;
    end
  end

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    advance && enable && at_last |=> !enable || slot == $past(base)); // R4

  AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    advance && enable && !at_last |=> !enable || slot == $past(slot) + AW'(ENTRY_BYTES)); // R3

endmodule

// File: rtl/erw_hold.sv
module erw_hold
  import erw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  cmp_rec_t in_rec,
  output logic     in_ready,
  input  logic     release_i,
  output logic     valid,
  output cmp_rec_t rec
);

  logic     valid_q;
  cmp_rec_t rec_q;

  assign in_ready = !valid_q;
  assign valid    = valid_q;
  assign rec      = rec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
    end else if (release_i) begin
      valid_q <= 1'b0;
    end else if (in_valid && !valid_q) begin
      valid_q <= 1'b1;
      rec_q   <= in_rec;
    end
  end

  AST_HOLD_KEEPS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !release_i |=> valid && $stable(rec)); // R5

endmodule

// File: rtl/erw_mem_port.sv
module erw_mem_port
  import erw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    addr_in,
  input  logic [TRB_W-1:0] data_in,
  input  logic             ioc_in,
  output logic             idle,
  output logic             req,
  output logic [AW-1:0]    addr,
  output logic [TRB_W-1:0] data,
  input  logic             ack,
  output logic             fire,
  output logic             done,
  output logic             done_ioc
);

  port_state_e      st_q;
  logic [AW-1:0]    addr_q;
  logic [TRB_W-1:0] data_q;
  logic             ioc_q;
  logic             done_q;
  logic             done_ioc_q;

  assign idle     = (st_q == PORT_IDLE);
  assign req      = (st_q == PORT_BUSY);
  assign addr     = addr_q;
  assign data     = data_q;
  assign fire     = req && ack;
  assign done     = done_q;
  assign done_ioc = done_ioc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PORT_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      ioc_q      <= 1'b0;
      done_q     <= 1'b0;
      done_ioc_q <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) done_ioc_q <= ioc_q;
      unique case (st_q)
        PORT_IDLE: if (go) begin
          st_q   <= PORT_BUSY;
          addr_q <= addr_in;
          data_q <= data_in;
          ioc_q  <= ioc_in;
        end
        PORT_BUSY: if (ack) st_q <= PORT_IDLE;
        default: st_q <= PORT_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(addr) && $stable(data)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req && ack |=> done); // R11

endmodule

// File: rtl/erw_full_flag.sv
module erw_full_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q;
  assign flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R7

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag); // R7

endmodule

// File: rtl/event_ring_writer.sv
module event_ring_writer
  import erw_pkg::*;
#(
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned ENTRY_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [31:0]       cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [31:0]       cfg_deq,
  input  logic              full_clr,
  output logic              ring_full,
  output logic [31:0]       cur_slot,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic              cmp_cc,
  input  logic              cmp_ioc,
  input  logic [15:0]       cmp_len,
  input  logic [31:0]       cmp_src,
  input  logic [31:0]       cmp_dst,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic [255:0]      mem_data,
  input  logic              mem_ack,
  output logic              trb_done,
  output logic              trb_done_ioc
);

  cmp_rec_t      in_rec;
  cmp_rec_t      held_rec;
  logic          held_valid;
  logic          port_idle;
  logic          port_fire;
  logic          slot_fresh;
  logic          slot_last;
  logic [AW-1:0] slot_addr;
  logic          slot_hits_deq;
  logic          ring_blocked;
  logic          issue_go;

  assign in_rec = '{cc: cmp_cc, ioc: cmp_ioc, len: cmp_len, src: cmp_src, dst: cmp_dst};

  // Named events used by the guards below.
  assign slot_hits_deq = !slot_fresh && (slot_addr == cfg_deq);
  assign ring_blocked  = cfg_enable && held_valid && port_idle && slot_hits_deq;
  assign issue_go      = cfg_enable && held_valid && port_idle && !slot_hits_deq;
  assign cur_slot      = slot_addr;

  erw_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cmp_valid),
    .in_rec    (in_rec),
    .in_ready  (cmp_ready),
    .release_i (port_fire),
    .valid     (held_valid),
    .rec       (held_rec)
  );

  erw_slot_tracker #(
    .SIZE_W      (SIZE_W),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cfg_enable),
    .base    (cfg_base),
    .size    (cfg_size),
    .advance (port_fire),
    .slot    (slot_addr),
    .fresh   (slot_fresh),
    .at_last (slot_last)
  );

  erw_mem_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (issue_go),
    .addr_in  (slot_addr),
    .data_in  (pack_entry(held_rec)),
    .ioc_in   (held_rec.ioc),
    .idle     (port_idle),
    .req      (mem_req),
    .addr     (mem_addr),
    .data     (mem_data),
    .ack      (mem_ack),
    .fire     (port_fire),
    .done     (trb_done),
    .done_ioc (trb_done_ioc)
  );

  erw_full_flag u_full (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ring_blocked),
    .clr   (full_clr),
    .flag  (ring_full)
  );

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !slot_fresh |-> mem_addr != $past(cfg_deq)); // R5

  AST_BLOCK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ring_blocked |=> !mem_req && !cmp_ready); // R5

  AST_LAST_WRAP_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    port_fire && slot_last && cfg_enable && (cfg_deq == cfg_base) && $stable(cfg_deq)
      |=> !mem_req); // R6

endmodule

// File: tb/event_ring_writer_test.sv
module event_ring_writer_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_enable;
  logic [31:0]  cfg_base;
  logic [15:0]  cfg_size;
  logic [31:0]  cfg_deq;
  logic         full_clr;
  logic         ring_full;
  logic [31:0]  cur_slot;
  logic         cmp_valid;
  logic         cmp_ready;
  logic         cmp_cc;
  logic         cmp_ioc;
  logic [15:0]  cmp_len;
  logic [31:0]  cmp_src;
  logic [31:0]  cmp_dst;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic [255:0] mem_data;
  logic         mem_ack = 1'b0;
  logic         trb_done;
  logic         trb_done_ioc;

  always #10 clk = ~clk;

  event_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_deq(cfg_deq), .full_clr(full_clr),
    .ring_full(ring_full), .cur_slot(cur_slot), .cmp_valid(cmp_valid),
    .cmp_ready(cmp_ready), .cmp_cc(cmp_cc), .cmp_ioc(cmp_ioc),
    .cmp_len(cmp_len), .cmp_src(cmp_src), .cmp_dst(cmp_dst),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ack(mem_ack), .trb_done(trb_done), .trb_done_ioc(trb_done_ioc)
  );

  typedef struct {
    logic [31:0]  addr;
    logic [255:0] data;
    logic         ioc;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;

  // Bench-side ring model
  logic [31:0] m_base;
  logic [31:0] m_slot;
  int          m_idx;
  int          m_size;
  bit          m_fresh;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic logic [255:0] expect_entry(input logic cc, input logic ioc,
      input logic [15:0] len, input logic [31:0] src, input logic [31:0] dst);
    logic [255:0] d;
    d          = '0;
    d[4:1]     = 4'd3;
    d[5]       = ioc;
    d[6]       = cc;
    d[31:16]   = len;
    d[63:32]   = src;
    d[95:64]   = dst;
    return d;
  endfunction

  task automatic model_restart(input logic [31:0] base, input int size);
    m_base  = base;
    m_size  = size;
    m_idx   = 0;
    m_fresh = 1'b1;
  endtask

  task automatic send_evt(input logic cc, input logic ioc, input logic [15:0] len,
                          input logic [31:0] src, input logic [31:0] dst);
    exp_t e;
    e.addr = m_fresh ? m_base : m_slot;
    e.data = expect_entry(cc, ioc, len, src, dst);
    e.ioc  = ioc;
    exp_q.push_back(e);
    if (m_idx + 1 >= m_size) begin
      m_slot = m_base;
      m_idx  = 0;
    end else begin
      m_slot = e.addr + 32'd32;
      m_idx  = m_idx + 1;
    end
    m_fresh = 1'b0;
    @(posedge clk); #1;
    cmp_valid = 1'b1; cmp_cc = cc; cmp_ioc = ioc;
    cmp_len = len; cmp_src = src; cmp_dst = dst;
    do @(negedge clk); while (!cmp_ready);
    @(posedge clk); #1;
    cmp_valid = 1'b0;
  endtask

  bit done_expect = 1'b0;
  bit done_ioc_exp = 1'b0;
  int lat_cnt = 0;
  int lat_tgt = 0;

  // Memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (done_expect) begin
      chk(trb_done === 1'b1 && trb_done_ioc === done_ioc_exp, "R11 done pulse",
          {trb_done, trb_done_ioc}, {1'b1, done_ioc_exp});
      done_expect = 1'b0;
    end else if (trb_done === 1'b1) begin
      chk(1'b0, "R11 unexpected done", 1, 0);
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req === 1'b1) begin
      if (lat_cnt < lat_tgt) begin
        lat_cnt++;
      end else begin
        exp_t e;
        mem_ack = 1'b1;
        lat_cnt = 0;
        lat_tgt = (lat_tgt + 1) % 3;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 write with nothing expected", mem_addr, 0);
        end else begin
          e = exp_q.pop_front();
          chk(mem_addr === e.addr, "R3/R4 write address", mem_addr, e.addr);
          chk(mem_data === e.data, "R9 entry layout", mem_data, e.data);
          done_expect  = 1'b1;
          done_ioc_exp = e.ioc;
        end
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !mem_req && !done_expect) break;
    end
    chk(exp_q.size() == 0, "R8 pending writes drained", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(posedge clk); #1 full_clr = 1'b1;
    @(posedge clk); #1 full_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic move_deq(input logic [31:0] d);
    @(posedge clk); #1 cfg_deq = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_base = 32'h1000; cfg_size = 16'd4;
    cfg_deq = 32'h1080; full_clr = 1'b0; cmp_valid = 1'b0; cmp_cc = 1'b0;
    cmp_ioc = 1'b0; cmp_len = '0; cmp_src = '0; cmp_dst = '0;
    model_restart(32'h1000, 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(mem_req === 1'b0 && ring_full === 1'b0 && trb_done === 1'b0 && cmp_ready === 1'b1,
        "R1 reset state", {mem_req, ring_full, trb_done, cmp_ready}, 4'b0001);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req === 1'b0 && ring_full === 1'b0 && cmp_ready === 1'b1,
        "R1 after release", {mem_req, ring_full, cmp_ready}, 3'b001);
    @(posedge clk); #1 cfg_enable = 1'b1;
    @(negedge clk);
    chk(cur_slot === 32'h1000, "R2 first slot at base", cur_slot, 32'h1000);

    // R2 R3 R4: one full pass and a wrap
    send_evt(1'b1, 1'b1, 16'h0040, 32'hA000_0000, 32'hB000_0000);
    send_evt(1'b0, 1'b0, 16'h0000, 32'hA000_0020, 32'hB000_0020);
    send_evt(1'b1, 1'b0, 16'hFFFF, 32'hA000_0040, 32'hB000_0040);
    send_evt(1'b1, 1'b1, 16'h1234, 32'hA000_0060, 32'hB000_0060);
    send_evt(1'b0, 1'b1, 16'h0100, 32'hA000_0080, 32'hB000_0080);
    wait_idle();
    chk(cur_slot === 32'h1020, "R3 slot after wrap step", cur_slot, 32'h1020);

    // R5 R7 R8: block on the dequeue pointer mid-ring
    move_deq(32'h1040);
    send_evt(1'b1, 1'b0, 16'h0011, 32'hC000_0000, 32'hD000_0000);
    wait_idle();
    send_evt(1'b1, 1'b1, 16'h0022, 32'hC000_0020, 32'hD000_0020);
    repeat (6) @(negedge clk);
    chk(mem_req === 1'b0, "R5 no write to dequeue slot", mem_req, 0);
    chk(cmp_ready === 1'b0, "R5 record held, ready low", cmp_ready, 0);
    chk(ring_full === 1'b1, "R7 full flag set", ring_full, 1);
    pulse_clr();
    chk(ring_full === 1'b1, "R7 clear lost while blocked", ring_full, 1);
    move_deq(32'h1000);
    wait_idle();
    pulse_clr();
    chk(ring_full === 1'b0, "R7 clear after release", ring_full, 0);

    // R6: return to base blocked when dequeue pointer equals base
    send_evt(1'b0, 1'b0, 16'h0033, 32'hE000_0000, 32'hF000_0000);
    wait_idle();
    send_evt(1'b1, 1'b1, 16'h0044, 32'hE000_0020, 32'hF000_0020);
    repeat (6) @(negedge clk);
    chk(mem_req === 1'b0 && ring_full === 1'b1, "R6 wrap blocked at base",
        {mem_req, ring_full}, 2'b01);
    chk(cur_slot === 32'h1000, "R6 pending slot is base", cur_slot, 32'h1000);
    move_deq(32'h1020);
    wait_idle();
    pulse_clr();

    // R12 restart at a new base; R4 ring of one entry
    @(posedge clk); #1 cfg_enable = 1'b0;
    cfg_base = 32'h2000; cfg_size = 16'd1; cfg_deq = 32'h3000;
    repeat (2) @(posedge clk); #1 cfg_enable = 1'b1;
    model_restart(32'h2000, 1);
    @(negedge clk);
    chk(cur_slot === 32'h2000, "R12 pointer back at new base", cur_slot, 32'h2000);
    send_evt(1'b1, 1'b0, 16'h0001, 32'h1111_0000, 32'h2222_0000);
    send_evt(1'b1, 1'b1, 16'h0002, 32'h1111_0020, 32'h2222_0020);
    send_evt(1'b0, 1'b0, 16'h0003, 32'h1111_0040, 32'h2222_0040);
    wait_idle();
    chk(cur_slot === 32'h2000, "R4 single-entry ring stays at base", cur_slot, 32'h2000);
    chk(ring_full === 1'b0, "R7 no full on free ring", ring_full, 0);
    report();
  end

endmodule